// File: doc/BRIEF.md
# Alternating-Logic Parallel Bus Checker

This block carries data words across a parallel bus with time redundancy, so that a bus line stuck at a constant level is caught. The transmitter side takes one word per handshake. It drives that word onto the bus in true form for one cycle, then drives its bitwise complement in the next cycle. A phase bit and a strobe travel with the data.

On a healthy bus every line therefore changes level between the two beats. The receiver side stores the true-form beat. When the complement beat arrives, it checks that every line alternated. If they all did, it delivers the stored word. If any did not, it raises an error pulse together with a per-line mask that marks the lines that held their level.

The bus lines between the two halves are top-level ports. The surrounding logic, or a test harness, can place anything between them, including stuck-at faults. Retransmission after an error is left to the user.

Top module: `altlink_top`

## Requirements
- R1: After a word W is accepted (in_valid and in_ready high at a clock edge), tx_strobe is 1, tx_phase is 0 and tx_data is W in the next cycle. In the cycle after that, tx_strobe is 1, tx_phase is 1 and tx_data is ~W.
- R2: in_ready is 1 when idle and 0 in the cycle that follows an acceptance, so at most one word is taken every two cycles.
- R3: When a phase-0 beat P0 is followed by a phase-1 beat P1 with P1 == ~P0, out_valid is 1 for exactly one cycle, in the cycle after the phase-1 beat is sampled, and out_data equals P0. Over a clean bus this is two cycles after the acceptance edge.
- R4: When the two beats are not complements, err is 1 for one cycle at that same point and out_valid stays 0. err_mask has bit i set exactly when line i carried the same level in both beats (mask = ~(P0 ^ P1)).
- R5: A line stuck at 0 is reported. For example, sending 8'h0B through a bus whose bit 1 is held at 0 gives err with err_mask = 8'h02.
- R6: A line stuck at 1 is reported in the same way, with its bit set in err_mask.
- R7: A phase-1 beat with no stored phase-0 beat is discarded. It produces neither out_valid nor err, and the next correct pair is still delivered.
- R8: A second phase-0 beat before any phase-1 beat replaces the stored word. The following pair check uses the newer word.
- R9: While reset is asserted and right after it is released, in_ready is 1 and tx_strobe, out_valid and err are 0.
- R10: out_valid and err are never 1 in the same cycle, and a completed check ends the pairing, so one pair gives one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered to the transmitter |
| in_ready | output | 1 | Transmitter can take a word |
| in_data | input | WIDTH | Word to send |
| tx_data | output | WIDTH | Bus data driven by the transmitter |
| tx_phase | output | 1 | 0 for the true beat, 1 for the complement beat |
| tx_strobe | output | 1 | Bus beat valid |
| rx_data | input | WIDTH | Bus data seen by the receiver |
| rx_phase | input | 1 | Phase seen by the receiver |
| rx_strobe | input | 1 | Beat valid seen by the receiver |
| out_valid | output | 1 | One-cycle pulse: checked word delivered |
| out_data | output | WIDTH | Delivered word (true form) |
| err | output | 1 | One-cycle pulse: the lines failed to alternate |
| err_mask | output | WIDTH | Lines that held their level across the pair |

## Verification
Each accepted word shows its true beat on the transmit lines one cycle after the accepting edge and its complement one cycle later. Its out_valid or err pulse is due two cycles after the accepting edge. For a pair injected straight onto the receive lines, the pulse is due one cycle after the phase-1 beat is sampled.

The driver records the due cycle of every expected result in a scoreboard queue. The monitor samples at the falling edge and compares both the result and the cycle in which it appears against the head of the queue. Any pulse that arrives with an empty queue is counted as a failure, which is how discarded beats are shown to have no effect.

// File: rtl/altlink_pkg.sv
package altlink_pkg;

   typedef enum logic {
      TX_TRUE_SLOT = 1'b0,
      TX_COMP_SLOT = 1'b1
   } tx_state_e;

   localparam logic BEAT_TRUE = 1'b0;
   localparam logic BEAT_COMP = 1'b1;

endpackage

// File: rtl/altlink_hold_detect.sv
module altlink_hold_detect #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] first_beat,
   input  logic [WIDTH-1:0] second_beat,
   output logic [WIDTH-1:0] held_lines
);
   // one comparator per bus line: set when the line did not toggle
   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign held_lines[i] = ~(first_beat[i] ^ second_beat[i]);
   end
endmodule

// File: rtl/altlink_tx.sv
module altlink_tx
   import altlink_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic [WIDTH-1:0] bus_data,
   output logic             bus_phase,
   output logic             bus_strobe
);
   tx_state_e        state_q;
   logic [WIDTH-1:0] word_q;

   assign in_ready = (state_q == TX_TRUE_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= TX_TRUE_SLOT;
         word_q     <= '0;
         bus_data   <= '0;
         bus_phase  <= BEAT_TRUE;
         bus_strobe <= 1'b0;
      end else begin
         unique case (state_q)
            TX_TRUE_SLOT: begin
               if (in_valid) begin
                  word_q     <= in_data;
                  bus_data   <= in_data;
                  bus_phase  <= BEAT_TRUE;
                  bus_strobe <= 1'b1;
                  state_q    <= TX_COMP_SLOT;
               end else begin
                  bus_strobe <= 1'b0;
               end
            end
            TX_COMP_SLOT: begin
               bus_data   <= ~word_q;
               bus_phase  <= BEAT_COMP;
               bus_strobe <= 1'b1;
               state_q    <= TX_TRUE_SLOT;
            end
            default: state_q <= TX_TRUE_SLOT;
         endcase
      end
   end

   assert_comp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && bus_phase == BEAT_TRUE) |=>
         (bus_strobe && bus_phase == BEAT_COMP && bus_data == ~$past(bus_data)));

   assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/altlink_rx.sv
module altlink_rx
   import altlink_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_data,
   input  logic             bus_phase,
   input  logic             bus_strobe,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data,
   output logic             err,
   output logic [WIDTH-1:0] err_mask
);
   logic [WIDTH-1:0] hold_q;
   logic             have_q;
   logic [WIDTH-1:0] held_lines;

   altlink_hold_detect #(.WIDTH(WIDTH)) detect_i (
      .first_beat  (hold_q),
      .second_beat (bus_data),
      .held_lines  (held_lines)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q    <= '0;
         have_q    <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         err       <= 1'b0;
         err_mask  <= '0;
      end else begin
         out_valid <= 1'b0;
         err       <= 1'b0;
         if (bus_strobe) begin
            if (bus_phase == BEAT_TRUE) begin
               hold_q <= bus_data;
               have_q <= 1'b1;
            end else begin
               have_q <= 1'b0;
               if (have_q) begin
                  if (|held_lines) begin
                     err      <= 1'b1;
                     err_mask <= held_lines;
                  end else begin
                     out_valid <= 1'b1;
                     out_data  <= hold_q;
                  end
               end
            end
         end
      end
   end

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_result_after_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || err) |-> $past(bus_strobe && bus_phase == BEAT_COMP));

   assert_orphan_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && bus_phase == BEAT_COMP && !have_q) |=> (!out_valid && !err));

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && err));

endmodule

// File: rtl/altlink_top.sv
module altlink_top #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic [WIDTH-1:0] tx_data,
   output logic             tx_phase,
   output logic             tx_strobe,
   input  logic [WIDTH-1:0] rx_data,
   input  logic             rx_phase,
   input  logic             rx_strobe,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data,
   output logic             err,
   output logic [WIDTH-1:0] err_mask
);
   if (WIDTH < 1) begin : g_bad_width
      $error("altlink_top: WIDTH must be at least 1");
   end

   altlink_tx #(.WIDTH(WIDTH)) tx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .bus_data   (tx_data),
      .bus_phase  (tx_phase),
      .bus_strobe (tx_strobe)
   );

   altlink_rx #(.WIDTH(WIDTH)) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_data   (rx_data),
      .bus_phase  (rx_phase),
      .bus_strobe (rx_strobe),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .err        (err),
      .err_mask   (err_mask)
   );

   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !err && !tx_strobe && in_ready));

endmodule

// File: tb/altlink_top_tb_top.sv
module altlink_top_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ready;
   logic [W-1:0] tx_data;
   logic         tx_phase, tx_strobe;
   logic [W-1:0] rx_data;
   logic         rx_phase, rx_strobe;
   logic         out_valid, err;
   logic [W-1:0] out_data, err_mask;

   // bus model with fault injection and a direct override path
   logic [W-1:0] stuck0 = '0, stuck1 = '0;
   logic         ovr = 1'b0, ovr_phase = 1'b0, ovr_strobe = 1'b0;
   logic [W-1:0] ovr_data = '0;

   assign rx_data   = ovr ? ovr_data   : ((tx_data & ~stuck0) | stuck1);
   assign rx_phase  = ovr ? ovr_phase  : tx_phase;
   assign rx_strobe = ovr ? ovr_strobe : tx_strobe;

   always #5 clk = ~clk;

   altlink_top #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .tx_data(tx_data), .tx_phase(tx_phase), .tx_strobe(tx_strobe),
      .rx_data(rx_data), .rx_phase(rx_phase), .rx_strobe(rx_strobe),
      .out_valid(out_valid), .out_data(out_data),
      .err(err), .err_mask(err_mask)
   );

   typedef struct {
      logic         is_err;
      logic [W-1:0] value;
      int           due;
      string        req;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic void push(input logic [W-1:0] p0, input logic [W-1:0] p1,
                                input int due, input string req);
      exp_t e;
      logic [W-1:0] m;
      m = ~(p0 ^ p1);
      e.is_err = (m != '0);
      e.value  = e.is_err ? m : p0;
      e.due    = due;
      e.req    = req;
      exp_q.push_back(e);
   endfunction

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && (out_valid || err)) begin
         if (exp_q.size() == 0) begin
            check(0, "R7", "unexpected result pulse", {W{err}}, '0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(cyc == e.due, e.req, "result cycle", W'(cyc), W'(e.due));
            check(err == e.is_err, e.req, "err vs out_valid", {W{err}}, {W{e.is_err}});
            check(!(out_valid && err), "R10", "both pulses", {W{out_valid}}, '0);
            if (e.is_err) check(err_mask == e.value, e.req, "err_mask", err_mask, e.value);
            else          check(out_data == e.value, e.req, "out_data", out_data, e.value);
         end
      end
   end

   // driver: one word through the transmitter, faults held over the whole pair
   task automatic send(input logic [W-1:0] w, input logic [W-1:0] s0,
                       input logic [W-1:0] s1, input string req);
      @(negedge clk);
      stuck0 = s0; stuck1 = s1;
      check(in_ready == 1'b1, "R2", "ready when idle", {W{in_ready}}, {W{1'b1}});
      in_valid = 1'b1; in_data = w;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      push((w & ~s0) | s1, (~w & ~s0) | s1, cyc + 2, req);
      check(tx_strobe && !tx_phase && tx_data == w, "R1", "true beat", tx_data, w);
      check(in_ready == 1'b0, "R2", "ready low after accept", {W{in_ready}}, '0);
      @(negedge clk);
      check(tx_strobe && tx_phase && tx_data == ~w, "R1", "complement beat", tx_data, ~w);
   endtask

   task automatic beat(input logic ph, input logic [W-1:0] d);
      ovr = 1'b1; ovr_strobe = 1'b1; ovr_phase = ph; ovr_data = d;
      @(negedge clk);
      ovr_strobe = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1, "R9", "in_ready in reset", {W{in_ready}}, {W{1'b1}});
      check(!out_valid && !err, "R9", "outputs in reset", {W{out_valid | err}}, '0);
      check(!tx_strobe, "R9", "strobe in reset", {W{tx_strobe}}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_strobe && in_ready, "R9", "idle after reset", {W{tx_strobe}}, '0);

      // clean words, several patterns
      send(8'hA5, '0, '0, "R3");
      send(8'h00, '0, '0, "R3");
      send(8'hFF, '0, '0, "R3");
      send(8'h3C, '0, '0, "R3");
      // stuck-at-0 on line 1 with 0B -> mask 02
      send(8'h0B, 8'h02, '0, "R5");
      // stuck-at-1 on line 6
      send(8'h0B, '0, 8'h40, "R6");
      // two faults, both polarities
      send(8'h5A, 8'h01, 8'h80, "R4");
      send(8'h77, '0, '0, "R3");
      repeat (3) @(negedge clk);

      // orphan phase-1 beat, then a correct pair still works
      @(negedge clk);
      beat(1'b1, 8'h12);
      @(negedge clk);
      check(!out_valid && !err, "R7", "orphan produced output", {W{out_valid | err}}, '0);
      beat(1'b0, 8'h12);
      push(8'h12, 8'hED, cyc + 1, "R7");
      beat(1'b1, 8'hED);
      repeat (2) @(negedge clk);
      // orphan right after a completed pair
      beat(1'b1, 8'hED);
      @(negedge clk);
      check(!out_valid && !err, "R10", "second phase-1 after pair", {W{out_valid | err}}, '0);

      // second phase-0 replaces the first
      beat(1'b0, 8'h11);
      beat(1'b0, 8'hC3);
      push(8'hC3, 8'h3C, cyc + 1, "R8");
      beat(1'b1, 8'h3C);
      repeat (2) @(negedge clk);

      // arbitrary mismatched pair injected directly
      beat(1'b0, 8'hF0);
      push(8'hF0, 8'hF5, cyc + 1, "R4");
      beat(1'b1, 8'hF5);
      ovr = 1'b0;
      repeat (4) @(negedge clk);

      check(exp_q.size() == 0, "R3", "results missing", W'(exp_q.size()), '0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            failures++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule